// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits between a host bus and a two-bank NOR flash array model. Each host write strobe carries a 20-bit word address and a 16-bit data word. The controller decodes one-cycle commands, which select the read source or clear errors, and two-cycle sequences, which start a word program or a block erase. It keeps an 8-bit status byte and launches each internal operation through a start pulse. The controller times the operation with a cycle counter and reports the end with a done pulse.

Reads are steered per bank. The bank is the top three address bits. A read that hits a bank with a running operation, or a bank with a half-written command sequence, returns the status byte. A read of any other bank returns array data, and no command is needed for this. When nothing is in flight, the last read-mode command picks the source: array data, identifier codes, status, or lock status.

A running operation can be suspended and later resumed. Asynchronous reset aborts any operation. A supply-lockout input blocks every modification request while it is asserted.

Top module: `fcmd_ctrl`

## Requirements
- R1: After reset, including a reset asserted while an operation runs, no operation is active. Reads return array data, and the status byte reads 80H.
- R2: Only bits 7..0 of a command write are decoded. The upper byte is ignored. Command FFH selects array reads, 90H identifier reads, 70H status reads and 71H lock-status reads.
- R3: In identifier mode, address bit 0 = 0 returns the manufacturer code (parameter, default 3CH) and address bit 0 = 1 returns the device code (default 5AH). Bits 15..8 read as zero on every source except array data.
- R4: In lock-status mode, bit 6 of the read word is 1 when the addressed block is unlocked and 0 when it is locked. All other bits are 0.
- R5: Word program is the command 40H followed by a write of target address and data. The target must lie in the program bank (address bits 19..17 = 111). If it does, op_start_o pulses in the cycle after the second write and carries that address and data. If it does not, no operation starts and status bit 4 is set.
- R6: Block erase is the command 20H followed by D0H at an address in the target block, and starts an erase (op_erase_o = 1). A second write other than D0H starts nothing and sets status bits 5 and 4.
- R7: Status byte layout: bit 7 ready, bit 6 suspended, bit 5 erase error, bit 4 program error, bit 3 block status after program, bits 2..0 zero. Ready reads 0 for exactly OP_CYCLES cycles after the accepted confirm write. Then op_done_o pulses for one cycle. Once an operation starts, the read mode becomes status.
- R8: While a sequence is half-written or an operation runs, a read of that bank returns status and a read of any other bank returns array data.
- R9: Command 50H, written while no operation runs, clears status bits 5, 4 and 3.
- R10: B0H written to the bank of the running operation suspends it. Status then shows bits 7 and 6 set, and the cycle count stops. While suspended, FFH gives array reads on every bank. D0H resumes the operation, clears bit 6 and selects status reads.
- R11: A program or erase whose target block is flagged locked (wr_locked_i) starts nothing. It sets bit 4 for a program or bit 5 for an erase.
- R12: While lockout_i is high, all writes are ignored, any half-written sequence is dropped, reads are forced to array mode, and no operation starts.
- R13: If op_fail_i is high when an operation completes, a program sets bits 4 and 3 and an erase sets bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset and power-down, aborts any operation |
| lockout_i | input | 1 | Low-supply lockout |
| wr_i | input | 1 | Host write strobe |
| wr_addr_i | input | 20 | Write address |
| wr_data_i | input | 16 | Write data or command |
| wr_locked_i | input | 1 | Block at wr_addr_i is locked |
| rd_addr_i | input | 20 | Read address |
| rd_data_o | output | 16 | Read data |
| arr_addr_o | output | 20 | Array read address |
| arr_rdata_i | input | 16 | Array read data |
| arr_locked_i | input | 1 | Block at arr_addr_o is locked |
| op_start_o | output | 1 | One-cycle pulse when an operation starts |
| op_erase_o | output | 1 | Operation is an erase (0 = program) |
| op_addr_o | output | 20 | Operation address |
| op_data_o | output | 16 | Program data |
| op_active_o | output | 1 | Operation running and not suspended |
| op_done_o | output | 1 | One-cycle pulse after completion |
| op_fail_i | input | 1 | Operation failed, sampled at completion |

## Verification
The assertions are checked on every cycle and cover the following:
- any read of the busy bank returns status with ready low;
- a start pulse always coincides with an active operation, and the done pulse follows its end;
- a suspended operation is never active and never completes;
- lockout never lets an operation start;
- reserved and upper bits read as zero.

Some behaviour can only be shown by the bench scenarios:
- the exact OP_CYCLES busy window;
- error-bit accumulation and clearing;
- the rejection paths (wrong bank, bad confirm, locked block);
- array reads on the suspended bank after FFH;
- abort by reset.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;
  typedef enum logic [1:0] {MD_ARRAY, MD_IDENT, MD_STATUS, MD_LOCK} rd_mode_e;
  typedef enum logic [1:0] {SQ_NONE, SQ_PROG, SQ_ERASE} seq_e;
  typedef enum logic [1:0] {SRC_ARRAY, SRC_IDENT, SRC_STATUS, SRC_LOCK} rd_src_e;

  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_LOCKRD  = 8'h71;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_PROG    = 8'h40;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;

  typedef struct packed {
    logic     set_mode;
    rd_mode_e mode;
    logic     clr_err;
    logic     seq_prog;
    logic     seq_erase;
    logic     suspend;
    logic     confirm;
  } cmd_dec_t;
endpackage

// File: rtl/fcmd_decode.sv
module fcmd_decode
  import fcmd_pkg::*;
(
  input  logic [7:0] cmd_i,
  output cmd_dec_t   dec_o
);
  always_comb begin
    dec_o      = '0;
    dec_o.mode = MD_ARRAY;
    case (cmd_i)
      CMD_ARRAY:   begin dec_o.set_mode = 1'b1; dec_o.mode = MD_ARRAY;  end
      CMD_IDENT:   begin dec_o.set_mode = 1'b1; dec_o.mode = MD_IDENT;  end
      CMD_STATUS:  begin dec_o.set_mode = 1'b1; dec_o.mode = MD_STATUS; end
      CMD_LOCKRD:  begin dec_o.set_mode = 1'b1; dec_o.mode = MD_LOCK;   end
      CMD_CLEAR:   dec_o.clr_err   = 1'b1;
      CMD_PROG:    dec_o.seq_prog  = 1'b1;
      CMD_ERASE:   dec_o.seq_erase = 1'b1;
      CMD_SUSPEND: dec_o.suspend   = 1'b1;
      CMD_CONFIRM: dec_o.confirm   = 1'b1;
      default:     ;
    endcase
  end
endmodule

// File: rtl/fcmd_optimer.sv
module fcmd_optimer #(
  parameter int unsigned OP_CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic suspend_i,
  input  logic resume_i,
  output logic active_o,
  output logic susp_o,
  output logic finish_o,
  output logic done_o
);
  localparam int unsigned CNT_W = (OP_CYCLES > 1) ? $clog2(OP_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(OP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic busy_q, susp_q, done_q;

  assign active_o = busy_q & ~susp_q;
  assign finish_o = active_o & (cnt_q == '0);
  assign susp_o   = susp_q;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      susp_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish_o;
      if (start_i) begin
        busy_q <= 1'b1;
        susp_q <= 1'b0;
        cnt_q  <= CNT_LOAD;
      end else begin
        if (active_o) begin
          if (cnt_q == '0) busy_q <= 1'b0;
          else             cnt_q  <= cnt_q - 1'b1;
        end
        // a suspend that lands on the final count is dropped
        if (suspend_i && !finish_o) susp_q <= 1'b1;
        else if (resume_i)          susp_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fcmd_rdmux.sv
module fcmd_rdmux
  import fcmd_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BANK_W = 3,
  parameter logic [7:0]  MFR_ID = 8'h3C,
  parameter logic [7:0]  DEV_ID = 8'h5A
) (
  input  logic [BANK_W-1:0] rd_bank_i,
  input  logic              rd_lsb_i,
  input  rd_mode_e          mode_i,
  input  logic              seq_pend_i,
  input  logic [BANK_W-1:0] seq_bank_i,
  input  logic              op_active_i,
  input  logic [BANK_W-1:0] op_bank_i,
  input  logic [7:0]        status_i,
  input  logic [DATA_W-1:0] arr_rdata_i,
  input  logic              arr_locked_i,
  output rd_src_e           src_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned PAD_W = DATA_W - 8;

  always_comb begin
    if (seq_pend_i && rd_bank_i == seq_bank_i)       src_o = SRC_STATUS;
    else if (op_active_i && rd_bank_i == op_bank_i)  src_o = SRC_STATUS;
    else if (seq_pend_i || op_active_i)              src_o = SRC_ARRAY;
    else begin
      case (mode_i)
        MD_IDENT:  src_o = SRC_IDENT;
        MD_STATUS: src_o = SRC_STATUS;
        MD_LOCK:   src_o = SRC_LOCK;
        default:   src_o = SRC_ARRAY;
      endcase
    end
  end

  always_comb begin
    case (src_o)
      SRC_IDENT:  rd_data_o = {{PAD_W{1'b0}}, (rd_lsb_i ? DEV_ID : MFR_ID)};
      SRC_STATUS: rd_data_o = {{PAD_W{1'b0}}, status_i};
      SRC_LOCK:   rd_data_o = {{PAD_W{1'b0}}, 1'b0, ~arr_locked_i, 6'b0};
      default:    rd_data_o = arr_rdata_i;
    endcase
  end
endmodule

// File: rtl/fcmd_ctrl.sv
module fcmd_ctrl
  import fcmd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned BANK_W     = 3,
  parameter logic [BANK_W-1:0] PROG_BANK = '1,
  parameter int unsigned OP_CYCLES  = 20,
  parameter logic [7:0]  MFR_ID     = 8'h3C,
  parameter logic [7:0]  DEV_ID     = 8'h5A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lockout_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_locked_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  input  logic [DATA_W-1:0] arr_rdata_i,
  input  logic              arr_locked_i,
  output logic              op_start_o,
  output logic              op_erase_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic              op_active_o,
  output logic              op_done_o,
  input  logic              op_fail_i
);
  localparam int unsigned BANK_LSB = ADDR_W - BANK_W;

  cmd_dec_t          dec;
  rd_mode_e          mode_q, mode_d;
  seq_e              seq_q, seq_d;
  logic [BANK_W-1:0] seq_bank_q, seq_bank_d;
  logic [2:0]        err_q, err_d;        // {erase, program, block}
  logic [ADDR_W-1:0] op_addr_q;
  logic [DATA_W-1:0] op_data_q;
  logic              op_erase_q, start_q;
  logic              start, start_erase, suspend, resume;
  logic              active, susp, finish;
  logic [BANK_W-1:0] wr_bank, rd_bank, op_bank;
  logic [7:0]        status;
  rd_src_e           rd_src;

  assign wr_bank = wr_addr_i[BANK_LSB +: BANK_W];
  assign rd_bank = rd_addr_i[BANK_LSB +: BANK_W];
  assign op_bank = op_addr_q[BANK_LSB +: BANK_W];
  assign status  = {~active, susp, err_q, 3'b000};

  fcmd_decode u_dec (.cmd_i(wr_data_i[7:0]), .dec_o(dec));

  fcmd_optimer #(.OP_CYCLES(OP_CYCLES)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .suspend_i(suspend),
    .resume_i (resume),
    .active_o (active),
    .susp_o   (susp),
    .finish_o (finish),
    .done_o   (op_done_o)
  );

  always_comb begin
    mode_d      = mode_q;
    seq_d       = seq_q;
    seq_bank_d  = seq_bank_q;
    err_d       = err_q;
    start       = 1'b0;
    start_erase = 1'b0;
    suspend     = 1'b0;
    resume      = 1'b0;
    if (finish && op_fail_i) begin
      if (op_erase_q) err_d[2]   = 1'b1;
      else            err_d[1:0] = 2'b11;
    end
    if (lockout_i) begin
      mode_d = MD_ARRAY;
      seq_d  = SQ_NONE;
    end else if (wr_i) begin
      if (seq_q == SQ_PROG) begin
        seq_d  = SQ_NONE;
        mode_d = MD_STATUS;
        if (wr_bank != PROG_BANK || wr_locked_i) err_d[1] = 1'b1;
        else                                     start    = 1'b1;
      end else if (seq_q == SQ_ERASE) begin
        seq_d  = SQ_NONE;
        mode_d = MD_STATUS;
        if (!dec.confirm)     err_d[2:1] = 2'b11;
        else if (wr_locked_i) err_d[2]   = 1'b1;
        else begin
          start       = 1'b1;
          start_erase = 1'b1;
        end
      end else if (active) begin
        suspend = dec.suspend && (wr_bank == op_bank);
      end else if (susp) begin
        if (dec.confirm) begin
          resume = 1'b1;
          mode_d = MD_STATUS;
        end else if (dec.set_mode) mode_d = dec.mode;
        else if (dec.clr_err)      err_d  = '0;
      end else begin
        if (dec.set_mode) mode_d = dec.mode;
        if (dec.clr_err)  err_d  = '0;
        if (dec.seq_prog || dec.seq_erase) begin
          seq_d      = dec.seq_prog ? SQ_PROG : SQ_ERASE;
          seq_bank_d = wr_bank;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MD_ARRAY;
      seq_q      <= SQ_NONE;
      seq_bank_q <= '0;
      err_q      <= '0;
      op_addr_q  <= '0;
      op_data_q  <= '0;
      op_erase_q <= 1'b0;
      start_q    <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      seq_q      <= seq_d;
      seq_bank_q <= seq_bank_d;
      err_q      <= err_d;
      start_q    <= start;
      if (start) begin
        op_addr_q  <= wr_addr_i;
        op_data_q  <= wr_data_i;
        op_erase_q <= start_erase;
      end
    end
  end

  fcmd_rdmux #(
    .DATA_W(DATA_W), .BANK_W(BANK_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
  ) u_rd (
    .rd_bank_i   (rd_bank),
    .rd_lsb_i    (rd_addr_i[0]),
    .mode_i      (mode_q),
    .seq_pend_i  (seq_q != SQ_NONE),
    .seq_bank_i  (seq_bank_q),
    .op_active_i (active),
    .op_bank_i   (op_bank),
    .status_i    (status),
    .arr_rdata_i (arr_rdata_i),
    .arr_locked_i(arr_locked_i),
    .src_o       (rd_src),
    .rd_data_o   (rd_data_o)
  );

  assign arr_addr_o  = rd_addr_i;
  assign op_start_o  = start_q;
  assign op_erase_o  = op_erase_q;
  assign op_addr_o   = op_addr_q;
  assign op_data_o   = op_data_q;
  assign op_active_o = active;
endmodule

// File: rtl/fcmd_ctrl_chk.sv
module fcmd_ctrl_chk
  import fcmd_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BANK_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lockout_i,
  input logic [BANK_W-1:0] rd_bank,
  input logic [BANK_W-1:0] op_bank,
  input logic              op_start_o,
  input logic              op_active_o,
  input logic              op_done_o,
  input logic              susp,
  input rd_src_e           rd_src,
  input logic [DATA_W-1:0] rd_data_o
);
  AST_START_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_start_o |-> op_active_o); // R5
  AST_DONE_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_done_o |-> ($past(op_active_o) && !op_active_o)); // R7
  AST_STATUS_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_src == SRC_STATUS) |-> (rd_data_o[2:0] == 3'b000)); // R7
  AST_UPPER_BYTE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_src != SRC_ARRAY) |-> (rd_data_o[DATA_W-1:8] == '0)); // R3
  AST_BUSY_BANK_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_active_o && rd_bank == op_bank) |-> (rd_src == SRC_STATUS && !rd_data_o[7])); // R8
  AST_SUSP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp |-> (!op_active_o && !op_done_o)); // R10
  AST_NO_START_LOCKOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lockout_i) |-> !op_start_o); // R12
endmodule

bind fcmd_ctrl fcmd_ctrl_chk #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lockout_i  (lockout_i),
  .rd_bank    (rd_bank),
  .op_bank    (op_bank),
  .op_start_o (op_start_o),
  .op_active_o(op_active_o),
  .op_done_o  (op_done_o),
  .susp       (susp),
  .rd_src     (rd_src),
  .rd_data_o  (rd_data_o)
);

// File: tb/fcmd_ctrl_tb.sv
`timescale 1ns/1ps
module fcmd_ctrl_tb;
  localparam int OPN = 20;
  localparam logic [15:0] SALT = 16'h9C3A;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        lockout = 0, wr = 0, wr_locked = 0, arr_locked = 0, op_fail = 0;
  logic [19:0] wr_addr = '0, rd_addr = '0, arr_addr, op_addr;
  logic [15:0] wr_data = '0, rd_data, arr_rdata, op_data;
  logic        op_start, op_erase, op_active, op_done;

  assign arr_rdata = arr_addr[15:0] ^ SALT;

  fcmd_ctrl #(.OP_CYCLES(OPN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .lockout_i(lockout), .wr_i(wr),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_locked_i(wr_locked),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .arr_addr_o(arr_addr),
    .arr_rdata_i(arr_rdata), .arr_locked_i(arr_locked),
    .op_start_o(op_start), .op_erase_o(op_erase), .op_addr_o(op_addr),
    .op_data_o(op_data), .op_active_o(op_active), .op_done_o(op_done),
    .op_fail_i(op_fail)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
    end
  endtask

  // reference model: mode 0 array,1 ident,2 status,3 lock; pend 0 none,1 prog,2 erase
  int m_mode, m_pend, m_cnt;
  logic [2:0] m_pb, m_ob;
  bit m_busy, m_susp, m_e5, m_e4, m_e3, m_start, m_done, m_erase;
  logic [19:0] m_oaddr;
  logic [15:0] m_odata;

  function automatic logic [15:0] exp_rd(input logic [19:0] a);
    logic [15:0] sr;
    bit act;
    act = m_busy && !m_susp;
    sr  = {8'h00, !act, m_susp, m_e5, m_e4, m_e3, 3'b000};
    if (m_pend != 0 && a[19:17] == m_pb) return sr;
    if (act && a[19:17] == m_ob) return sr;
    if (m_pend != 0 || act) return a[15:0] ^ SALT;
    case (m_mode)
      1: return a[0] ? 16'h005A : 16'h003C;
      2: return sr;
      3: return arr_locked ? 16'h0000 : 16'h0040;
      default: return a[15:0] ^ SALT;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit act, fin, so;
    int po;
    logic [7:0] c;
    logic [2:0] b;
    if (!rst_n) begin
      m_mode = 0; m_pend = 0; m_cnt = 0; m_pb = 0; m_ob = 0;
      m_busy = 0; m_susp = 0; m_e5 = 0; m_e4 = 0; m_e3 = 0;
      m_start = 0; m_done = 0; m_erase = 0; m_oaddr = 0; m_odata = 0;
    end else begin
      act = m_busy && !m_susp;
      fin = act && (m_cnt == 0);
      so  = m_susp;
      po  = m_pend;
      m_start = 0;
      m_done  = fin;
      if (act) begin
        if (m_cnt == 0) m_busy = 0; else m_cnt = m_cnt - 1;
      end
      if (fin && op_fail) begin
        if (m_erase) m_e5 = 1; else begin m_e4 = 1; m_e3 = 1; end
      end
      if (lockout) begin
        m_mode = 0; m_pend = 0;
      end else if (wr) begin
        c = wr_data[7:0];
        b = wr_addr[19:17];
        if (po != 0) begin
          m_pend = 0; m_mode = 2;
          if (po == 1 && (b != 3'b111 || wr_locked)) m_e4 = 1;
          else if (po == 2 && c != 8'hD0) begin m_e5 = 1; m_e4 = 1; end
          else if (po == 2 && wr_locked) m_e5 = 1;
          else begin
            m_busy = 1; m_susp = 0; m_cnt = OPN - 1; m_start = 1;
            m_ob = b; m_erase = (po == 2); m_oaddr = wr_addr; m_odata = wr_data;
          end
        end else if (act) begin
          if (c == 8'hB0 && b == m_ob && !fin) m_susp = 1;
        end else begin
          if (so && c == 8'hD0) begin m_susp = 0; m_mode = 2; end
          else begin
            case (c)
              8'hFF: m_mode = 0;
              8'h90: m_mode = 1;
              8'h70: m_mode = 2;
              8'h71: m_mode = 3;
              8'h50: begin m_e5 = 0; m_e4 = 0; m_e3 = 0; end
              8'h40: if (!so) begin m_pend = 1; m_pb = b; end
              8'h20: if (!so) begin m_pend = 2; m_pb = b; end
              default: ;
            endcase
          end
        end
      end
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R8 read", {16'h0, rd_data}, {16'h0, exp_rd(rd_addr)});
      chk("R7 active", {31'h0, op_active}, {31'h0, m_busy && !m_susp});
      chk("R7 done", {31'h0, op_done}, {31'h0, m_done});
      chk("R5 start", {31'h0, op_start}, {31'h0, m_start});
      if (m_start) begin
        chk("R5 addr", {12'h0, op_addr}, {12'h0, m_oaddr});
        chk("R5 data", {16'h0, op_data}, {16'h0, m_odata});
        chk("R6 kind", {31'h0, op_erase}, {31'h0, m_erase});
      end
    end
  end

  task automatic wr_cmd(input logic [19:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    wr = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr = 0;
  endtask

  task automatic rd(input logic [19:0] a, output logic [15:0] v);
    @(posedge clk); #1;
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic report;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state
    rd(20'h00010, v); chk("R1 array after reset", v, 16'h0010 ^ SALT);
    wr_cmd(20'h0, 16'h0070); rd(20'h0, v); chk("R1 status 80H", v, 16'h0080);
    // R2 upper byte ignored, R3 identifier codes
    wr_cmd(20'h0, 16'hAB90);
    rd(20'h00000, v); chk("R2 ident via AB90", v, 16'h003C);
    rd(20'h00001, v); chk("R3 device code", v, 16'h005A);
    // R4 lock status
    wr_cmd(20'h0, 16'h0071);
    arr_locked = 1; rd(20'h40000, v); chk("R4 locked", v, 16'h0000);
    arr_locked = 0; rd(20'h40002, v); chk("R4 unlocked", v, 16'h0040);
    wr_cmd(20'h0, 16'h00FF); rd(20'h12345, v); chk("R2 array", v, 16'h2345 ^ SALT);
    // R5 program in bank 111
    wr_cmd(20'hE0000, 16'h0040);
    wr_cmd(20'hE0123, 16'h1234);
    chk("R5 start pulse", {31'h0, op_start}, 32'h1);
    chk("R5 op addr", {12'h0, op_addr}, 32'hE0123);
    chk("R5 op data", {16'h0, op_data}, 32'h1234);
    rd(20'hE0000, v); chk("R8 busy bank status", v, 16'h0000);
    rd(20'h00100, v); chk("R8 other bank array", v, 16'h0100 ^ SALT);
    repeat (OPN + 2) @(posedge clk);
    rd(20'hE0000, v); chk("R7 ready after op", v, 16'h0080);
    rd(20'h00100, v); chk("R7 auto status mode", v, 16'h0080);
    // R5 wrong bank
    wr_cmd(20'h00000, 16'h0040);
    wr_cmd(20'h00010, 16'h5555);
    chk("R5 no start wrong bank", {31'h0, op_start}, 32'h0);
    rd(20'h0, v); chk("R5 program error", v, 16'h0090);
    wr_cmd(20'h0, 16'h0050); rd(20'h0, v); chk("R9 clear", v, 16'h0080);
    // R6 bad confirm
    wr_cmd(20'h40000, 16'h0020);
    wr_cmd(20'h40000, 16'h00FF);
    chk("R6 no start bad confirm", {31'h0, op_start}, 32'h0);
    rd(20'h40000, v); chk("R6 sequence error", v, 16'h00B0);
    wr_cmd(20'h0, 16'h0050);
    // R6 erase, R8 pending steering, R10 suspend/resume
    wr_cmd(20'h40000, 16'h0020);
    rd(20'h40005, v); chk("R8 pending bank status", v, 16'h0080);
    rd(20'hE0000, v); chk("R8 pending other bank", v, 16'h0000 ^ SALT);
    wr_cmd(20'h40000, 16'h00D0);
    chk("R6 erase start", {31'h0, op_start}, 32'h1);
    chk("R6 erase kind", {31'h0, op_erase}, 32'h1);
    repeat (5) @(posedge clk);
    wr_cmd(20'h40000, 16'h00B0);
    rd(20'h40000, v); chk("R10 suspended status", v, 16'h00C0);
    repeat (40) @(posedge clk);
    #1 chk("R10 stays suspended", {31'h0, op_active}, 32'h0);
    wr_cmd(20'h0, 16'h00FF);
    rd(20'h40010, v); chk("R10 array read in suspended bank", v, 16'h0010 ^ SALT);
    wr_cmd(20'h40000, 16'h00D0);
    rd(20'h40000, v); chk("R10 resumed busy", v, 16'h0000);
    repeat (OPN + 2) @(posedge clk);
    rd(20'h40000, v); chk("R7 erase done", v, 16'h0080);
    // R11 locked targets
    wr_locked = 1;
    wr_cmd(20'hE0000, 16'h0040); wr_cmd(20'hE0001, 16'h0777);
    chk("R11 no program start", {31'h0, op_start}, 32'h0);
    rd(20'hE0000, v); chk("R11 program locked", v, 16'h0090);
    wr_cmd(20'h0, 16'h0050);
    wr_cmd(20'h40000, 16'h0020); wr_cmd(20'h40000, 16'h00D0);
    chk("R11 no erase start", {31'h0, op_start}, 32'h0);
    rd(20'h40000, v); chk("R11 erase locked", v, 16'h00A0);
    wr_cmd(20'h0, 16'h0050);
    wr_locked = 0;
    // R13 failure at completion
    op_fail = 1;
    wr_cmd(20'hE0000, 16'h0040); wr_cmd(20'hE0002, 16'h0ABC);
    repeat (OPN + 2) @(posedge clk);
    rd(20'hE0000, v); chk("R13 program fail", v, 16'h0098);
    op_fail = 0;
    wr_cmd(20'h0, 16'h0050); rd(20'h0, v); chk("R9 clear all", v, 16'h0080);
    // R12 lockout
    wr_cmd(20'h0, 16'h00FF);
    lockout = 1;
    wr_cmd(20'h0, 16'h0070);
    rd(20'h00020, v); chk("R12 array held", v, 16'h0020 ^ SALT);
    wr_cmd(20'hE0000, 16'h0040); wr_cmd(20'hE0000, 16'h1111);
    chk("R12 no start", {31'h0, op_start}, 32'h0);
    lockout = 0;
    rd(20'hE0000, v); chk("R12 nothing pending", v, 16'h0000 ^ SALT);
    // R1 reset aborts a running erase
    wr_cmd(20'h40000, 16'h0020); wr_cmd(20'h40000, 16'h00D0);
    repeat (3) @(posedge clk);
    #1 rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    chk("R1 abort", {31'h0, op_active}, 32'h0);
    rd(20'h40000, v); chk("R1 array after abort", v, 16'h0000 ^ SALT);
    wr_cmd(20'h0, 16'h0070); rd(20'h0, v); chk("R1 status after abort", v, 16'h0080);
    repeat (2) @(posedge clk);
    report();
  end
endmodule